// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block turns the sampled pins of one or more 32-bit GPIO banks into interrupt events. For every pin it runs one of three detectors: a level detector, a single-edge detector with a selectable direction, or an either-edge detector. Each event is latched in a sticky per-bank status register. A hidden per-bank mask decides which latched events reach a single interrupt line, which is shared by all banks.

The block sits behind an address decoder and an input synchroniser, so it sees only decoded write strobes and pins that are already in the clock domain. A write picks a bank with `wrBank`, raises one or more strobes, and supplies a 32-bit data word. A read port returns the status, mask and configuration of the bank chosen by `rdBank`. Edges are found by comparing each new pin sample with the previous one. The previous sample keeps tracking the pins while reset is held, so a level that is already present when reset is released is not taken as an edge.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every bank reads type all ones, with polarity, any-edge, mask and status at zero, and `irqOut` low.
- R2: For a pin with type bit 1 and any-edge bit 1, every change of the pin between two samples sets its status bit.
- R3: For a pin with type bit 1 and any-edge bit 0, a change sets its status bit only when the new pin level equals the polarity bit. Polarity 1 selects rising edges and polarity 0 selects falling edges.
- R4: For a pin with type bit 0, the status bit is set on every cycle in which the pin equals the polarity bit. A clear while that level is still present therefore does not remove the bit.
- R5: A status-clear write clears the status bits where the data is 1 and leaves the bits where the data is 0. When a detection and a clear hit the same bit in the same cycle, the detection wins.
- R6: An enable write clears the mask bits where the data is 1, and a disable write sets them. If both hit the same bit in the same cycle, the bit ends up set. The mask is observed through the read port.
- R7: `irqOut` is registered. On each clock it takes the OR over all banks of (status AND NOT mask) as that state stood before the edge.
- R8: The status register reflects a pin sample one clock after the edge that samples it. A configuration write first affects detection on the clock after the write.
- R9: The previous sample follows the pins during reset. A level held across the release of reset gives no edge, and a change after release is detected.
- R10: A write changes only the bank chosen by `wrBank`.
- R11: A type, polarity or any-edge write loads the whole 32-bit data word into that register, and the value reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NUM_BANKS*BANK_W | Synchronised pin samples; bank b occupies bits b*BANK_W upward |
| wrBank | input | SEL_W | Bank selected by the write strobes |
| wrData | input | BANK_W | Write data word |
| wrType | input | 1 | Load the type register (1 = edge, 0 = level) |
| wrPolarity | input | 1 | Load the polarity register |
| wrAnyEdge | input | 1 | Load the any-edge register |
| wrEnable | input | 1 | Clear the mask bits set in the data |
| wrDisable | input | 1 | Set the mask bits set in the data |
| wrStatClr | input | 1 | Clear the status bits set in the data |
| rdBank | input | SEL_W | Bank shown on the read outputs |
| rdStatus | output | BANK_W | Status of the read bank |
| rdMask | output | BANK_W | Mask of the read bank |
| rdType | output | BANK_W | Type register of the read bank |
| rdPolarity | output | BANK_W | Polarity register of the read bank |
| rdAnyEdge | output | BANK_W | Any-edge register of the read bank |
| irqOut | output | 1 | Combined registered interrupt |

## Verification
Directed steps move single pins through falling edges, rising edges and held levels under each detector setting. These steps separate rising-edge from falling-edge selection, either-edge detection from single-edge detection, and a level that re-asserts after a clear from an edge that stays cleared. Further directed steps place a configuration write in the same cycle as a matching pin level, and put enable, disable and clear writes on both banks. These show the one-cycle latency of configuration writes and confirm that a write does not reach the other bank. A long random phase then toggles sparse pin bits while it mixes in all six strobes. This exposes detections and clears that land together, and checks the registered lag of the interrupt against a bench model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Decoded per-bank write strobes, handed from control to datapath.
  typedef struct packed {
    logic typeWr;
    logic polWr;
    logic anyWr;
    logic enWr;
    logic disWr;
    logic clrWr;
  } bankStrobe_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int SEL_W     = 1
) (
  input  logic [SEL_W-1:0]            wrBank,
  input  logic                        wrType,
  input  logic                        wrPolarity,
  input  logic                        wrAnyEdge,
  input  logic                        wrEnable,
  input  logic                        wrDisable,
  input  logic                        wrStatClr,
  output bankStrobe_t [NUM_BANKS-1:0] bankStrb
);

  // Route each strobe to the single bank that the write selects.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
    logic hit;
    assign hit = (wrBank == SEL_W'(b));
    assign bankStrb[b].typeWr = hit & wrType;
    assign bankStrb[b].polWr  = hit & wrPolarity;
    assign bankStrb[b].anyWr  = hit & wrAnyEdge;
    assign bankStrb[b].enWr   = hit & wrEnable;
    assign bankStrb[b].disWr  = hit & wrDisable;
    assign bankStrb[b].clrWr  = hit & wrStatClr;
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int BANK_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BANK_W-1:0] pinIn,
  input  bankStrobe_t       strb,
  input  logic [BANK_W-1:0] wrData,
  output logic [BANK_W-1:0] statusQ,
  output logic [BANK_W-1:0] maskQ,
  output logic [BANK_W-1:0] typeQ,
  output logic [BANK_W-1:0] polQ,
  output logic [BANK_W-1:0] anyQ
);

  logic [BANK_W-1:0] prevQ;
  logic [BANK_W-1:0] edgeSeen;
  logic [BANK_W-1:0] levelMatch;
  logic [BANK_W-1:0] hitVec;
  logic [BANK_W-1:0] clrVec;
  logic [BANK_W-1:0] enVec;
  logic [BANK_W-1:0] disVec;
  logic [BANK_W-1:0] statusD;
  logic [BANK_W-1:0] maskD;

  // The previous sample is not reset: it keeps tracking the pins while reset
  // is held, so a level present at release is not seen as an edge.
  always_ff @(posedge clk) begin
    prevQ <= pinIn;
  end

  always_comb begin
    edgeSeen   = pinIn ^ prevQ;
    levelMatch = ~(pinIn ^ polQ);
    // Edge pins: any change if any-edge, else only toward the polarity level.
    // Level pins: whenever the pin sits at the polarity level.
    hitVec     = (typeQ & edgeSeen & (anyQ | levelMatch)) | (~typeQ & levelMatch);
    clrVec     = strb.clrWr ? wrData : '0;
    enVec      = strb.enWr  ? wrData : '0;
    disVec     = strb.disWr ? wrData : '0;
    statusD    = (statusQ & ~clrVec) | hitVec;
    maskD      = (maskQ & ~enVec) | disVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      typeQ   <= '1;
      polQ    <= '0;
      anyQ    <= '0;
      maskQ   <= '0;
      statusQ <= '0;
    end else begin
      if (strb.typeWr) typeQ <= wrData;
      if (strb.polWr)  polQ  <= wrData;
      if (strb.anyWr)  anyQ  <= wrData;
      maskQ   <= maskD;
      statusQ <= statusD;
    end
  end

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  parameter int SEL_W     = 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_BANKS*BANK_W-1:0] pinIn,
  input  bankStrobe_t [NUM_BANKS-1:0] bankStrb,
  input  logic [BANK_W-1:0]           wrData,
  input  logic [SEL_W-1:0]            rdBank,
  output logic [BANK_W-1:0]           rdStatus,
  output logic [BANK_W-1:0]           rdMask,
  output logic [BANK_W-1:0]           rdType,
  output logic [BANK_W-1:0]           rdPolarity,
  output logic [BANK_W-1:0]           rdAnyEdge,
  output logic [NUM_BANKS*BANK_W-1:0] statusAll,
  output logic [NUM_BANKS*BANK_W-1:0] maskAll,
  output logic [NUM_BANKS*BANK_W-1:0] typeAll,
  output logic [NUM_BANKS*BANK_W-1:0] polAll,
  output logic                        irqOut
);

  logic [NUM_BANKS*BANK_W-1:0] anyAll;
  logic [NUM_BANKS-1:0]        pending;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_irq_bank #(.BANK_W(BANK_W)) u_bank (
      .clk     (clk),
      .rstN    (rstN),
      .pinIn   (pinIn[b*BANK_W +: BANK_W]),
      .strb    (bankStrb[b]),
      .wrData  (wrData),
      .statusQ (statusAll[b*BANK_W +: BANK_W]),
      .maskQ   (maskAll[b*BANK_W +: BANK_W]),
      .typeQ   (typeAll[b*BANK_W +: BANK_W]),
      .polQ    (polAll[b*BANK_W +: BANK_W]),
      .anyQ    (anyAll[b*BANK_W +: BANK_W])
    );
    assign pending[b] = |(statusAll[b*BANK_W +: BANK_W] & ~maskAll[b*BANK_W +: BANK_W]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |pending;
  end

  // AND-OR read selector; an unused select code returns zero.
  always_comb begin
    rdStatus   = '0;
    rdMask     = '0;
    rdType     = '0;
    rdPolarity = '0;
    rdAnyEdge  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (rdBank == SEL_W'(b)) begin
        rdStatus   = rdStatus   | statusAll[b*BANK_W +: BANK_W];
        rdMask     = rdMask     | maskAll[b*BANK_W +: BANK_W];
        rdType     = rdType     | typeAll[b*BANK_W +: BANK_W];
        rdPolarity = rdPolarity | polAll[b*BANK_W +: BANK_W];
        rdAnyEdge  = rdAnyEdge  | anyAll[b*BANK_W +: BANK_W];
      end
    end
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  localparam int SEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_BANKS*BANK_W-1:0] pinIn,
  input  logic [SEL_W-1:0]            wrBank,
  input  logic [BANK_W-1:0]           wrData,
  input  logic                        wrType,
  input  logic                        wrPolarity,
  input  logic                        wrAnyEdge,
  input  logic                        wrEnable,
  input  logic                        wrDisable,
  input  logic                        wrStatClr,
  input  logic [SEL_W-1:0]            rdBank,
  output logic [BANK_W-1:0]           rdStatus,
  output logic [BANK_W-1:0]           rdMask,
  output logic [BANK_W-1:0]           rdType,
  output logic [BANK_W-1:0]           rdPolarity,
  output logic [BANK_W-1:0]           rdAnyEdge,
  output logic                        irqOut
);

  bankStrobe_t [NUM_BANKS-1:0] bankStrb;
  logic [NUM_BANKS*BANK_W-1:0] statusAll;
  logic [NUM_BANKS*BANK_W-1:0] maskAll;
  logic [NUM_BANKS*BANK_W-1:0] typeAll;
  logic [NUM_BANKS*BANK_W-1:0] polAll;

  gpio_irq_ctrl #(.NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W)) u_ctrl (
    .wrBank     (wrBank),
    .wrType     (wrType),
    .wrPolarity (wrPolarity),
    .wrAnyEdge  (wrAnyEdge),
    .wrEnable   (wrEnable),
    .wrDisable  (wrDisable),
    .wrStatClr  (wrStatClr),
    .bankStrb   (bankStrb)
  );

  gpio_irq_datapath #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .SEL_W(SEL_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .pinIn      (pinIn),
    .bankStrb   (bankStrb),
    .wrData     (wrData),
    .rdBank     (rdBank),
    .rdStatus   (rdStatus),
    .rdMask     (rdMask),
    .rdType     (rdType),
    .rdPolarity (rdPolarity),
    .rdAnyEdge  (rdAnyEdge),
    .statusAll  (statusAll),
    .maskAll    (maskAll),
    .typeAll    (typeAll),
    .polAll     (polAll),
    .irqOut     (irqOut)
  );

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  parameter int SEL_W     = 1
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NUM_BANKS*BANK_W-1:0] pinIn,
  input logic [SEL_W-1:0]            wrBank,
  input logic [BANK_W-1:0]           wrData,
  input logic                        wrType,
  input logic                        wrEnable,
  input logic                        wrDisable,
  input logic                        wrStatClr,
  input logic                        irqOut,
  input logic [NUM_BANKS*BANK_W-1:0] statusAll,
  input logic [NUM_BANKS*BANK_W-1:0] maskAll,
  input logic [NUM_BANKS*BANK_W-1:0] typeAll,
  input logic [NUM_BANKS*BANK_W-1:0] polAll
);

  logic [NUM_BANKS*BANK_W-1:0] clrVec;
  logic [NUM_BANKS*BANK_W-1:0] enVec;
  logic [NUM_BANKS*BANK_W-1:0] disVec;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_vec
    assign clrVec[b*BANK_W +: BANK_W] = (wrStatClr && wrBank == SEL_W'(b)) ? wrData : '0;
    assign enVec[b*BANK_W +: BANK_W]  = (wrEnable  && wrBank == SEL_W'(b)) ? wrData : '0;
    assign disVec[b*BANK_W +: BANK_W] = (wrDisable && wrBank == SEL_W'(b)) ? wrData : '0;
  end

  // A status bit may only fall where a clear write aimed at it.
  assert_status_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (($past(statusAll) & ~statusAll & ~$past(clrVec)) == '0));

  // Mask bits fall only through enable and rise only through disable.
  assert_mask_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    (($past(maskAll) & ~maskAll & ~$past(enVec)) == '0));
  assert_mask_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((~$past(maskAll) & maskAll & ~$past(disVec)) == '0));

  // Registered combined interrupt follows unmasked status one clock later.
  assert_irq_lag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut == (|$past(statusAll & ~maskAll))));

  // A level pin at its active level must show status on the next clock.
  assert_level_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    (($past(~typeAll & ~(pinIn ^ polAll)) & ~statusAll) == '0));

  // The type register changes only after a type write.
  assert_type_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    (typeAll != $past(typeAll)) |-> $past(wrType));

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(
  .NUM_BANKS (NUM_BANKS),
  .BANK_W    (BANK_W),
  .SEL_W     (SEL_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pinIn     (pinIn),
  .wrBank    (wrBank),
  .wrData    (wrData),
  .wrType    (wrType),
  .wrEnable  (wrEnable),
  .wrDisable (wrDisable),
  .wrStatClr (wrStatClr),
  .irqOut    (irqOut),
  .statusAll (statusAll),
  .maskAll   (maskAll),
  .typeAll   (typeAll),
  .polAll    (polAll)
);

// File: tb/gpio_irq_detect_bench.sv
`timescale 1ns/1ps
module gpio_irq_detect_bench;

  localparam int NB = 2;
  localparam int W  = 32;
  localparam int SW = 1;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NB*W-1:0] pinsBus = '1;
  logic [SW-1:0]   wrBank = '0;
  logic [W-1:0]    wrData = '0;
  logic            wrType = 0, wrPolarity = 0, wrAnyEdge = 0;
  logic            wrEnable = 0, wrDisable = 0, wrStatClr = 0;
  logic [SW-1:0]   rdBank = '0;
  logic [W-1:0]    rdStatus, rdMask, rdType, rdPolarity, rdAnyEdge;
  logic            irqOut;

  always #5 clk = ~clk;

  gpio_irq_detect #(.NUM_BANKS(NB), .BANK_W(W)) u_gpio_irq_detect (
    .clk(clk), .rstN(rstN), .pinIn(pinsBus), .wrBank(wrBank), .wrData(wrData),
    .wrType(wrType), .wrPolarity(wrPolarity), .wrAnyEdge(wrAnyEdge),
    .wrEnable(wrEnable), .wrDisable(wrDisable), .wrStatClr(wrStatClr),
    .rdBank(rdBank), .rdStatus(rdStatus), .rdMask(rdMask), .rdType(rdType),
    .rdPolarity(rdPolarity), .rdAnyEdge(rdAnyEdge), .irqOut(irqOut)
  );

  // Reference model built from the requirements.
  logic [W-1:0] mType [NB];
  logic [W-1:0] mPol  [NB];
  logic [W-1:0] mAny  [NB];
  logic [W-1:0] mMask [NB];
  logic [W-1:0] mStat [NB];
  logic [W-1:0] mPrev [NB];
  logic         mIrq;

  int unsigned total = 0;
  int unsigned bad   = 0;

  task automatic chk(input string tag, input string what, input int b,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s bank %0d actual %h expected %h", tag, what, b, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    for (int b = 0; b < NB; b++) begin
      rdBank = SW'(b);
      #1;
      chk(tag, "status", b, rdStatus, mStat[b]);
      chk(tag, "mask", b, rdMask, mMask[b]);
      chk(tag, "type", b, rdType, mType[b]);
      chk(tag, "polarity", b, rdPolarity, mPol[b]);
      chk(tag, "anyedge", b, rdAnyEdge, mAny[b]);
    end
    chk(tag, "irq", 0, {31'b0, irqOut}, {31'b0, mIrq});
  endtask

  task automatic chkBits(input string tag, input string what, input int b,
                         input logic [W-1:0] sel, input logic [W-1:0] exp);
    rdBank = SW'(b);
    #1;
    if (what == "mask")      chk(tag, what, b, rdMask & sel, exp);
    else if (what == "type") chk(tag, what, b, rdType & sel, exp);
    else                     chk(tag, what, b, rdStatus & sel, exp);
  endtask

  task automatic modelReset();
    for (int b = 0; b < NB; b++) begin
      mType[b] = '1; mPol[b] = '0; mAny[b] = '0; mMask[b] = '0; mStat[b] = '0;
      mPrev[b] = pinsBus[b*W +: W];
    end
    mIrq = 1'b0;
  endtask

  task automatic modelClock();
    logic acc;
    acc = 1'b0;
    for (int b = 0; b < NB; b++) begin
      logic [W-1:0] p, hit, clrV, enV, disV;
      logic         sel;
      sel  = (wrBank == SW'(b));
      p    = pinsBus[b*W +: W];
      hit  = (mType[b] & (p ^ mPrev[b]) & (mAny[b] | ~(p ^ mPol[b]))) |
             (~mType[b] & ~(p ^ mPol[b]));
      clrV = (sel && wrStatClr) ? wrData : '0;
      enV  = (sel && wrEnable)  ? wrData : '0;
      disV = (sel && wrDisable) ? wrData : '0;
      acc  = acc | (|(mStat[b] & ~mMask[b]));
      mStat[b] = (mStat[b] & ~clrV) | hit;
      mMask[b] = (mMask[b] & ~enV) | disV;
      if (sel && wrType)     mType[b] = wrData;
      if (sel && wrPolarity) mPol[b]  = wrData;
      if (sel && wrAnyEdge)  mAny[b]  = wrData;
      mPrev[b] = p;
    end
    mIrq = acc;
  endtask

  task automatic step();
    modelClock();
    @(posedge clk);
    @(negedge clk);
    wrType = 0; wrPolarity = 0; wrAnyEdge = 0;
    wrEnable = 0; wrDisable = 0; wrStatClr = 0;
  endtask

  // kind: 0 type, 1 polarity, 2 any-edge, 3 enable, 4 disable, 5 status clear
  task automatic doWrite(input int kind, input int b, input logic [W-1:0] d);
    wrBank = SW'(b);
    wrData = d;
    case (kind)
      0: wrType = 1;
      1: wrPolarity = 1;
      2: wrAnyEdge = 1;
      3: wrEnable = 1;
      4: wrDisable = 1;
      default: wrStatClr = 1;
    endcase
    step();
  endtask

  task automatic setPin(input int b, input int bitIdx, input logic v);
    pinsBus[b*W + bitIdx] = v;
    step();
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1 / R9: reset with pins high, release on a falling edge of the clock.
    rstN = 1'b0;
    pinsBus = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelReset();
    checkAll("R1");
    chkBits("R1", "type", 0, '1, '1);
    chk("R1", "irq", 0, {31'b0, irqOut}, 32'h0);

    step();
    checkAll("R9");
    chkBits("R9", "status", 0, '1, '0);

    // R3: default falling-edge detection, bank 0 bit 0.
    setPin(0, 0, 1'b0);
    checkAll("R3");
    chkBits("R3", "status", 0, 32'h1, 32'h1);
    chk("R7", "irq", 0, {31'b0, irqOut}, 32'h0);
    step();
    chk("R7", "irq", 0, {31'b0, irqOut}, 32'h1);

    doWrite(5, 0, 32'h1);
    checkAll("R5");
    chkBits("R5", "status", 0, 32'h1, 32'h0);
    setPin(0, 0, 1'b1);
    checkAll("R3");
    chkBits("R3", "status", 0, 32'h1, 32'h0);

    // R3: rising edge with polarity 1.
    doWrite(1, 0, 32'h1);
    setPin(0, 0, 1'b0);
    chkBits("R3", "status", 0, 32'h1, 32'h0);
    setPin(0, 0, 1'b1);
    checkAll("R3");
    chkBits("R3", "status", 0, 32'h1, 32'h1);

    // R2: either edge on bit 1.
    doWrite(2, 0, 32'h2);
    setPin(0, 1, 1'b0);
    checkAll("R2");
    chkBits("R2", "status", 0, 32'h2, 32'h2);
    doWrite(5, 0, '1);
    setPin(0, 1, 1'b1);
    checkAll("R2");
    chkBits("R2", "status", 0, 32'h2, 32'h2);

    // R4: level detection on bit 2, active low.
    doWrite(5, 0, '1);
    doWrite(0, 0, ~32'h4);
    setPin(0, 2, 1'b0);
    checkAll("R4");
    chkBits("R4", "status", 0, 32'h4, 32'h4);
    doWrite(5, 0, 32'h4);
    checkAll("R4");
    chkBits("R4", "status", 0, 32'h4, 32'h4);
    setPin(0, 2, 1'b1);
    chkBits("R4", "status", 0, 32'h4, 32'h4);
    doWrite(5, 0, 32'h4);
    checkAll("R4");
    chkBits("R4", "status", 0, 32'h4, 32'h0);

    // R6 / R7: masking on bank 1 bit 5.
    setPin(1, 5, 1'b0);
    checkAll("R10");
    chkBits("R10", "status", 1, 32'h20, 32'h20);
    doWrite(4, 1, 32'h20);
    checkAll("R6");
    chkBits("R6", "mask", 1, 32'h20, 32'h20);
    chkBits("R10", "mask", 0, '1, 32'h0);
    step();
    step();
    checkAll("R7");
    chk("R7", "irq", 0, {31'b0, irqOut}, 32'h0);
    wrEnable = 1;
    doWrite(4, 1, 32'h20);
    checkAll("R6");
    chkBits("R6", "mask", 1, 32'h20, 32'h20);
    doWrite(3, 1, 32'h20);
    chkBits("R6", "mask", 1, 32'h20, 32'h0);
    chk("R7", "irq", 0, {31'b0, irqOut}, 32'h0);
    step();
    checkAll("R7");
    chk("R7", "irq", 0, {31'b0, irqOut}, 32'h1);

    // R5: clear with zero data changes nothing.
    doWrite(5, 1, 32'h0);
    checkAll("R5");
    chkBits("R5", "status", 1, 32'h20, 32'h20);

    // R8: a config write takes effect one clock later.
    doWrite(1, 1, 32'h80);
    doWrite(0, 1, ~32'h80);
    chkBits("R8", "status", 1, 32'h80, 32'h0);
    step();
    checkAll("R8");
    chkBits("R8", "status", 1, 32'h80, 32'h80);
    chkBits("R10", "type", 0, '1, ~32'h4);

    // R11: full-word load and readback.
    doWrite(2, 1, 32'hA5C3_0F96);
    checkAll("R11");

    // Random phase.
    for (int i = 0; i < 3000; i++) begin
      for (int b = 0; b < NB; b++)
        pinsBus[b*W +: W] = pinsBus[b*W +: W] ^ ($urandom & $urandom & $urandom);
      wrBank     = SW'($urandom % NB);
      wrData     = (($urandom % 4) == 0) ? '1 : $urandom;
      wrType     = (($urandom % 16) == 0);
      wrPolarity = (($urandom % 16) == 0);
      wrAnyEdge  = (($urandom % 16) == 0);
      wrEnable   = (($urandom % 6) == 0);
      wrDisable  = (($urandom % 8) == 0);
      wrStatClr  = (($urandom % 3) == 0);
      step();
      checkAll("R8");
    end

    finishRun();
  end

endmodule